// File: doc/BRIEF.md
# Priority Interrupt Controller Command Port

This block is the byte-wide, two-address register port of an eight-line priority interrupt controller. It decodes every byte the host writes and keeps the controller's configuration: the line mask, the vector base, the nesting and automatic end-of-interrupt modes, and the rotating priority base. It also issues one-cycle clear and set pulses for the in-service register, which the separate priority resolver holds.

Address 0 takes three kinds of write, chosen by bits 4 and 3 of the byte:

- an initialization start,
- a read/poll command,
- an operation command.

Address 1 takes the mask byte or the next initialization word. Which of these it takes depends on a four-step sequencer.

Reads return one of three things: the request register, the in-service register, or the mask. If poll is armed, a read instead returns the resolver's current winner and acknowledges it.

The port is a plain register interface with single-cycle strobes. It has no handshake and no back-pressure. Each strobe is taken on the clock edge where it is high. Every output, including read data, changes on that same edge and is stable in the cycle that follows. Read data holds its value until the next accepted read.

Top module: `pic_cmd_port`

## Requirements
- R1: A write to address 0 with bit 4 set starts initialization. It clears the mask, the vector base, the rotation base, and the following flags: nesting, automatic end-of-interrupt, rotate-on-auto-EOI, special mask, poll and read select. It also pulses `init_clr` for one cycle, stores bit 0 as `need_word4` and bit 1 as `single_mode`, and moves the sequencer to its base step.
- R2: In the base step, a write to address 1 loads `vec_base` from data bits 7:3. The next step is then:
  - the mode step if single and word 4 is needed;
  - the ready step if single only;
  - otherwise the cascade step.
- R3: In the cascade step, the written data is ignored and the sequencer goes to the mode step if word 4 is needed, else to the ready step. In the mode step, bit 4 becomes `fully_nested` and bit 1 becomes `auto_eoi`, and the sequencer returns to the ready step.
- R4: After reset the sequencer is in the ready step and every register output is 0. In the ready step, a write to address 1 loads `mask_reg`.
- R5: A write to address 0 with bit 4 clear and bit 3 set is a read/poll command:
  - bit 2 arms poll;
  - if bit 1 is set, bit 0 chooses the read source (1 for in-service, 0 for request);
  - if bit 6 is set, bit 5 becomes `special_mask`.
- R6: Any other address-0 write is an operation command with its code in bits 7:5. Code 0 clears `rot_on_aeoi` and code 4 sets it.
- R7: Code 1 pulses `isr_clr` for the highest-priority set bit of `isr_in`. Priority runs upward from `rot_base`, modulo 8. If `isr_in` is zero, nothing changes.
- R8: Code 5 behaves like code 1 and also sets `rot_base` to the cleared line + 1, modulo 8.
- R9: Code 3 pulses `isr_clr` for line bits 2:0. Code 7 does the same and also sets `rot_base` to that line + 1.
- R10: Code 6 sets `rot_base` to line bits 2:0 + 1, modulo 8. Code 2 changes nothing.
- R11: A read while poll is armed returns 0x80 OR `win_line` when `win_valid` is high, or 0x00 when it is low, and then disarms poll. When there is a winner, the read also:
  - pulses `ack_stb` with `ack_line`;
  - pulses `isr_set` for that line if `auto_eoi` is 0;
  - otherwise, if `rot_on_aeoi` is 1, sets `rot_base` to line + 1.
- R12: A read with poll not armed returns `mask_reg` at address 1. At address 0 it returns `isr_in` or `irr_in`, according to the read select.
- R13: If `rd_en` and `wr_en` are high in the same cycle, the write is taken and the read is ignored: `rdata`, poll and `ack_stb` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register address (0 or 1) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| isr_in | input | 8 | In-service register from the resolver |
| irr_in | input | 8 | Request register from the resolver |
| win_line | input | 3 | Resolver's winning line |
| win_valid | input | 1 | Resolver has a winner |
| rdata | output | 8 | Read data, registered |
| mask_reg | output | 8 | Line mask |
| vec_base | output | 5 | Vector base (upper five bits) |
| single_mode | output | 1 | Single-controller mode |
| need_word4 | output | 1 | Fourth initialization word expected |
| fully_nested | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| rot_base | output | 3 | Line with lowest priority + 1 (highest-priority line) |
| isr_clr | output | 8 | One-cycle in-service clear pulse |
| isr_set | output | 8 | One-cycle in-service set pulse |
| ack_stb | output | 1 | Poll acknowledge pulse |
| ack_line | output | 3 | Acknowledged line |
| init_clr | output | 1 | One-cycle pulse to clear resolver state |

## Verification
The assertions check, on every cycle, that:
- an initialization start clears the mask and enters the base step;
- a ready-step mask write lands;
- the cascade step is never entered in single mode;
- the clear and set pulses are one-hot at most, and a set never appears under automatic end-of-interrupt;
- acknowledge data matches the read byte;
- a poll read always disarms;
- a colliding read leaves the read data alone.

Only the bench scenarios can show the following:
- the priority search that non-specific end-of-interrupt performs across all rotation bases and in-service patterns;
- the four sequencer paths;
- the per-code rotation results;
- the contents of poll and register reads.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);
  localparam int DW    = 8;
  localparam int VBW   = DW - LW;

  typedef enum logic [1:0] {
    SEQ_READY = 2'd0,
    SEQ_BASE  = 2'd1,
    SEQ_CASC  = 2'd2,
    SEQ_MODE  = 2'd3
  } seq_step_e;

  typedef enum logic [2:0] {
    OP_ROT_OFF  = 3'd0,
    OP_NS_EOI   = 3'd1,
    OP_NOP      = 3'd2,
    OP_SP_EOI   = 3'd3,
    OP_ROT_ON   = 3'd4,
    OP_NS_ROT   = 3'd5,
    OP_SET_BASE = 3'd6,
    OP_SP_ROT   = 3'd7
  } op_code_e;

  // Highest-priority set bit, scanning upward from base; MSB is the found flag.
  function automatic logic [LW:0] top_line(input logic [LINES-1:0] vec,
                                           input logic [LW-1:0] base);
    logic [LW:0] res;
    logic [LW-1:0] idx;
    res = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      idx = base + LW'(k);
      if (vec[idx]) res = {1'b1, idx};
    end
    return res;
  endfunction

  function automatic logic [LINES-1:0] line_bit(input logic [LW-1:0] l);
    return LINES'(1) << l;
  endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_hit,
  input  logic           port_hit,
  input  logic [DW-1:0]  wdata,
  output seq_step_e      step,
  output logic [LINES-1:0] mask,
  output logic [VBW-1:0] vec_base,
  output logic           single,
  output logic           need4,
  output logic           nested,
  output logic           aeoi
);
  seq_step_e after_base;

  always_comb begin
    if (single) after_base = need4 ? SEQ_MODE : SEQ_READY;
    else        after_base = SEQ_CASC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= SEQ_READY;
      mask     <= '0;
      vec_base <= '0;
      single   <= 1'b0;
      need4    <= 1'b0;
      nested   <= 1'b0;
      aeoi     <= 1'b0;
    end else if (init_hit) begin
      step     <= SEQ_BASE;
      mask     <= '0;
      vec_base <= '0;
      nested   <= 1'b0;
      aeoi     <= 1'b0;
      need4    <= wdata[0];
      single   <= wdata[1];
    end else if (port_hit) begin
      unique case (step)
        SEQ_READY: mask <= wdata[LINES-1:0];
        SEQ_BASE: begin
          vec_base <= wdata[DW-1:LW];
          step     <= after_base;
        end
        SEQ_CASC: step <= need4 ? SEQ_MODE : SEQ_READY;
        SEQ_MODE: begin
          nested <= wdata[4];
          aeoi   <= wdata[1];
          step   <= SEQ_READY;
        end
        default: step <= SEQ_READY;
      endcase
    end
  end
endmodule

// File: rtl/pic_opcmd.sv
module pic_opcmd
  import pic_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_hit,
  input  logic             op_hit,
  input  logic [DW-1:0]    wdata,
  input  logic [LINES-1:0] isr_in,
  input  logic             poll_rot_req,
  input  logic [LW-1:0]    poll_rot_line,
  output logic [LW-1:0]    rot_base,
  output logic             rot_aeoi,
  output logic [LINES-1:0] isr_clr
);
  op_code_e    code;
  logic [LW:0] found;
  logic [LW-1:0] spec_line;

  assign code      = op_code_e'(wdata[DW-1:DW-3]);
  assign found     = top_line(isr_in, rot_base);
  assign spec_line = wdata[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_base <= '0;
      rot_aeoi <= 1'b0;
      isr_clr  <= '0;
    end else begin
      isr_clr <= '0;
      if (init_hit) begin
        rot_base <= '0;
        rot_aeoi <= 1'b0;
      end else if (op_hit) begin
        unique case (code)
          OP_ROT_OFF, OP_ROT_ON: rot_aeoi <= code[2];
          OP_NS_EOI, OP_NS_ROT: begin
            if (found[LW]) begin
              isr_clr <= line_bit(found[LW-1:0]);
              if (code == OP_NS_ROT) rot_base <= found[LW-1:0] + 1'b1;
            end
          end
          OP_SP_EOI:   isr_clr <= line_bit(spec_line);
          OP_SET_BASE: rot_base <= spec_line + 1'b1;
          OP_SP_ROT: begin
            isr_clr  <= line_bit(spec_line);
            rot_base <= spec_line + 1'b1;
          end
          default: ;
        endcase
      end else if (poll_rot_req) begin
        rot_base <= poll_rot_line + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_rdpoll.sv
module pic_rdpoll
  import pic_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_hit,
  input  logic             rp_hit,
  input  logic             rd_go,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LINES-1:0] isr_in,
  input  logic [LINES-1:0] irr_in,
  input  logic [LINES-1:0] mask,
  input  logic [LW-1:0]    win_line,
  input  logic             win_valid,
  input  logic             aeoi,
  input  logic             rot_aeoi,
  output logic [DW-1:0]    rdata,
  output logic             ack_stb,
  output logic [LW-1:0]    ack_line,
  output logic [LINES-1:0] isr_set,
  output logic             smm,
  output logic             poll,
  output logic             poll_rot_req,
  output logic [LW-1:0]    poll_rot_line
);
  logic sel_isr;
  logic [DW-1:0] reg_view;

  assign poll_rot_req  = rd_go & poll & win_valid & aeoi & rot_aeoi;
  assign poll_rot_line = win_line;

  always_comb begin
    if (addr)         reg_view = DW'(mask);
    else if (sel_isr) reg_view = DW'(isr_in);
    else              reg_view = DW'(irr_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      ack_stb  <= 1'b0;
      ack_line <= '0;
      isr_set  <= '0;
      smm      <= 1'b0;
      poll     <= 1'b0;
      sel_isr  <= 1'b0;
    end else begin
      ack_stb <= 1'b0;
      isr_set <= '0;
      if (init_hit) begin
        poll    <= 1'b0;
        sel_isr <= 1'b0;
        smm     <= 1'b0;
      end else if (rp_hit) begin
        if (wdata[2]) poll    <= 1'b1;
        if (wdata[1]) sel_isr <= wdata[0];
        if (wdata[6]) smm     <= wdata[5];
      end else if (rd_go) begin
        if (poll) begin
          poll <= 1'b0;
          if (win_valid) begin
            rdata    <= {1'b1, {(DW-1-LW){1'b0}}, win_line};
            ack_stb  <= 1'b1;
            ack_line <= win_line;
            if (!aeoi) isr_set <= line_bit(win_line);
          end else begin
            rdata <= '0;
          end
        end else begin
          rdata <= reg_view;
        end
      end
    end
  end
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_cmd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         addr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [7:0]   wdata,
  input  logic [7:0]   isr_in,
  input  logic [7:0]   irr_in,
  input  logic [2:0]   win_line,
  input  logic         win_valid,
  output logic [7:0]   rdata,
  output logic [7:0]   mask_reg,
  output logic [4:0]   vec_base,
  output logic         single_mode,
  output logic         need_word4,
  output logic         fully_nested,
  output logic         auto_eoi,
  output logic         rot_on_aeoi,
  output logic         special_mask,
  output logic [2:0]   rot_base,
  output logic [7:0]   isr_clr,
  output logic [7:0]   isr_set,
  output logic         ack_stb,
  output logic [2:0]   ack_line,
  output logic         init_clr
);
  logic      cmd_wr, init_hit, rp_hit, op_hit, port_hit, rd_go;
  logic      poll_rot_req, poll_armed;
  logic [LW-1:0] poll_rot_line;
  seq_step_e seq_step;

  assign cmd_wr   = wr_en & ~addr;
  assign init_hit = cmd_wr & wdata[4];
  assign rp_hit   = cmd_wr & ~wdata[4] & wdata[3];
  assign op_hit   = cmd_wr & ~wdata[4] & ~wdata[3];
  assign port_hit = wr_en & addr;
  assign rd_go    = rd_en & ~wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_clr <= 1'b0;
    else        init_clr <= init_hit;
  end

  pic_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .init_hit(init_hit), .port_hit(port_hit),
    .wdata(wdata), .step(seq_step), .mask(mask_reg), .vec_base(vec_base),
    .single(single_mode), .need4(need_word4), .nested(fully_nested),
    .aeoi(auto_eoi)
  );

  pic_opcmd u_op (
    .clk(clk), .rst_n(rst_n), .init_hit(init_hit), .op_hit(op_hit),
    .wdata(wdata), .isr_in(isr_in), .poll_rot_req(poll_rot_req),
    .poll_rot_line(poll_rot_line), .rot_base(rot_base),
    .rot_aeoi(rot_on_aeoi), .isr_clr(isr_clr)
  );

  pic_rdpoll u_rd (
    .clk(clk), .rst_n(rst_n), .init_hit(init_hit), .rp_hit(rp_hit),
    .rd_go(rd_go), .addr(addr), .wdata(wdata), .isr_in(isr_in),
    .irr_in(irr_in), .mask(mask_reg), .win_line(win_line),
    .win_valid(win_valid), .aeoi(auto_eoi), .rot_aeoi(rot_on_aeoi),
    .rdata(rdata), .ack_stb(ack_stb), .ack_line(ack_line),
    .isr_set(isr_set), .smm(special_mask), .poll(poll_armed),
    .poll_rot_req(poll_rot_req), .poll_rot_line(poll_rot_line)
  );
endmodule

// File: rtl/pic_cmd_port_chk.sv
module pic_cmd_port_chk
  import pic_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] mask_reg,
  input logic       single_mode,
  input logic       auto_eoi,
  input logic [7:0] isr_clr,
  input logic [7:0] isr_set,
  input logic       ack_stb,
  input logic [2:0] ack_line,
  input logic       init_clr,
  input logic       poll_armed,
  input seq_step_e  seq_step
);
  p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (mask_reg == 8'h00 && init_clr && seq_step == SEQ_BASE));

  p_no_casc_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_step == SEQ_CASC) |-> !single_mode);

  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && seq_step == SEQ_READY) |=> (mask_reg == $past(wdata)));

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr));

  p_set_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_set != 8'h00) |-> (!auto_eoi && ack_stb && $onehot0(isr_set)));

  p_ack_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> (rdata == {5'b10000, ack_line}));

  p_poll_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> !poll_armed);

  p_write_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> (!ack_stb && $stable(rdata)));
endmodule

bind pic_cmd_port pic_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .mask_reg(mask_reg),
  .single_mode(single_mode), .auto_eoi(auto_eoi), .isr_clr(isr_clr),
  .isr_set(isr_set), .ack_stb(ack_stb), .ack_line(ack_line),
  .init_clr(init_clr), .poll_armed(poll_armed), .seq_step(seq_step)
);

// File: tb/pic_cmd_port_test.sv
module pic_cmd_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, isr_in = '0, irr_in = '0;
  logic [2:0] win_line = '0;
  logic win_valid = 1'b0;
  logic [7:0] rdata, mask_reg, isr_clr, isr_set;
  logic [4:0] vec_base;
  logic single_mode, need_word4, fully_nested, auto_eoi, rot_on_aeoi;
  logic special_mask, ack_stb, init_clr;
  logic [2:0] rot_base, ack_line;
  int nvec = 0, nerr = 0;

  always #10 clk = ~clk;

  pic_cmd_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .isr_in(isr_in), .irr_in(irr_in), .win_line(win_line),
    .win_valid(win_valid), .rdata(rdata), .mask_reg(mask_reg),
    .vec_base(vec_base), .single_mode(single_mode), .need_word4(need_word4),
    .fully_nested(fully_nested), .auto_eoi(auto_eoi),
    .rot_on_aeoi(rot_on_aeoi), .special_mask(special_mask),
    .rot_base(rot_base), .isr_clr(isr_clr), .isr_set(isr_set),
    .ack_stb(ack_stb), .ack_line(ack_line), .init_clr(init_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // Expected highest-priority line, scanning upward from base.
  function automatic int exp_top(input logic [7:0] v, input int b);
    for (int k = 0; k < 8; k++)
      if (v[(b + k) % 8]) return (b + k) % 8;
    return -1;
  endfunction

  task automatic init_seq(input bit n4, input bit sg, input logic [7:0] w4);
    wr(0, 8'h10 | {6'b0, sg, n4});
    wr(1, 8'h40);
    if (!sg) wr(1, 8'hFF);
    if (n4) wr(1, w4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk("R4 reset mask", mask_reg, 0);
    chk("R4 reset rdata", rdata, 0);
    chk("R4 reset rot_base", rot_base, 0);
    chk("R4 reset flags", {single_mode, need_word4, fully_nested, auto_eoi, rot_on_aeoi, special_mask}, 0);
    wr(1, 8'h5A);
    chk("R4 mask load", mask_reg, 8'h5A);

    // R1 R2 R3: all sequencer paths
    for (int c = 0; c < 4; c++) begin
      bit n4, sg;
      n4 = c[0]; sg = c[1];
      wr(0, 8'h10 | {6'b0, sg, n4});
      chk("R1 init mask clear", mask_reg, 0);
      chk("R1 init pulse", init_clr, 1);
      chk("R1 flags", {single_mode, need_word4}, {sg, n4});
      wr(1, 8'h9F - 8'(c));
      chk("R2 vector base", vec_base, 5'h13);
      if (!sg) begin
        wr(1, 8'hFF);
        chk("R3 cascade word ignored", mask_reg, 0);
      end
      if (n4) begin
        wr(1, 8'h12);
        chk("R3 mode word", {fully_nested, auto_eoi}, 2'b11);
      end
      wr(1, 8'hC3 ^ 8'(c));
      chk("R2 back to ready", mask_reg, 8'hC3 ^ 8'(c));
      chk("R3 mode kept", {fully_nested, auto_eoi}, {n4, n4});
    end
    init_seq(1, 1, 8'h00);
    wr(1, 8'h81);
    chk("R3 aeoi off", auto_eoi, 0);

    // R12 R5 readback
    irr_in = 8'hA5; isr_in = 8'h3C;
    wr(0, 8'h0A); rd(0); chk("R12 request read", rdata, 8'hA5);
    wr(0, 8'h0B); rd(0); chk("R12 in-service read", rdata, 8'h3C);
    wr(0, 8'h09); rd(0); chk("R5 select held when bit1 clear", rdata, 8'h3C);
    rd(1); chk("R12 mask read", rdata, 8'h81);
    wr(0, 8'h68); chk("R5 special mask set", special_mask, 1);
    wr(0, 8'h28); chk("R5 special mask held", special_mask, 1);
    wr(0, 8'h48); chk("R5 special mask clear", special_mask, 0);

    // R7 R8 exhaustive non-specific EOI sweep
    for (int b = 0; b < 8; b++) begin
      for (int v = 0; v < 256; v++) begin
        int t; bit rot;
        wr(0, 8'hC0 | 8'((b + 7) % 8));
        chk("R10 set base", rot_base, b);
        rot = ((v ^ b) & 1) != 0;
        isr_in = 8'(v);
        wr(0, rot ? 8'hA0 : 8'h20);
        t = exp_top(8'(v), b);
        if (t < 0) begin
          chk("R7 no clear when empty", isr_clr, 0);
          chk("R8 base kept when empty", rot_base, b);
        end else begin
          chk(rot ? "R8 clear" : "R7 clear", isr_clr, 1 << t);
          chk(rot ? "R8 rotate" : "R7 base kept", rot_base, rot ? (t + 1) % 8 : b);
        end
      end
    end

    // R9 R10 R6 specific commands
    for (int l = 0; l < 8; l++) begin
      wr(0, 8'hC0);
      wr(0, 8'h60 | 8'(l));
      chk("R9 specific clear", isr_clr, 1 << l);
      chk("R9 specific keeps base", rot_base, 1);
      wr(0, 8'hE0 | 8'(l));
      chk("R9 specific rotate clear", isr_clr, 1 << l);
      chk("R9 specific rotate base", rot_base, (l + 1) % 8);
    end
    wr(0, 8'h80); chk("R6 rotate-on-aeoi set", rot_on_aeoi, 1);
    wr(0, 8'h40);
    chk("R10 code 2 no clear", isr_clr, 0);
    chk("R10 code 2 base", rot_base, 0);
    chk("R10 code 2 flag", rot_on_aeoi, 1);
    wr(0, 8'h00); chk("R6 rotate-on-aeoi clear", rot_on_aeoi, 0);

    // R11 poll sweep, auto-EOI off
    irr_in = 8'h96;
    for (int v = 0; v < 2; v++) begin
      for (int l = 0; l < 8; l++) begin
        win_line = 3'(l); win_valid = v[0];
        wr(0, 8'h0E);
        rd(0);
        chk("R11 poll byte", rdata, v ? (8'h80 | 8'(l)) : 8'h00);
        chk("R11 ack", {ack_stb, ack_line}, v ? {1'b1, 3'(l)} : {1'b0, ack_line});
        chk("R11 isr set", isr_set, v ? (1 << l) : 0);
        rd(0);
        chk("R11 poll disarmed", {ack_stb, rdata}, {1'b0, 8'h96});
      end
    end

    // R11 poll with auto-EOI and rotation
    init_seq(1, 1, 8'h02);
    wr(0, 8'h80);
    for (int l = 0; l < 8; l++) begin
      win_line = 3'(l); win_valid = 1'b1;
      wr(0, 8'h0C); rd(0);
      chk("R11 aeoi no set", isr_set, 0);
      chk("R11 aeoi rotate", rot_base, (l + 1) % 8);
    end
    wr(0, 8'h00); wr(0, 8'hC3);
    wr(0, 8'h0C); rd(0);
    chk("R11 aeoi no rotate", rot_base, 4);

    // R13 simultaneous read and write
    wr(0, 8'h0E); rd(1);
    chk("R13 setup poll read", rdata, 8'h87);
    wr(0, 8'h0C);
    @(negedge clk); addr = 1'b1; wdata = 8'h3E; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R13 write taken", mask_reg, 8'h3E);
    chk("R13 read ignored", {ack_stb, rdata}, {1'b0, 8'h87});
    win_line = 3'd5;
    rd(0);
    chk("R13 poll still armed", rdata, 8'h85);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule